// File: doc/BRIEF.md
# Time-Shared Determinant Datapath

This block evaluates a fixed arithmetic expression over six signed operands a, b, c, d, e and f:
result = (a·b)·((c+d) + floor(e·f / 4)) − (a + e·f)·((c+d)·b).
It has only two multipliers and a single add/subtract unit. A hard-wired five-step schedule reuses them, and a small controller drives the operand multiplexers and the enables of the temporary registers in each step.

A one-cycle start pulse, sampled while the block is idle, captures all six operands. The block then runs alone: it holds busy high, ignores further start pulses and ignores later changes on the operand pins. When the last step has finished, it places the full-width result on its output and pulses done for one cycle. The result stays on the output until the next computation completes. The divide by four is an arithmetic right shift by two, so it is plain wiring and takes no step of its own.

Top module: `det_sched_top`

## Requirements
- R1: A synchronous active-low reset (rst_n low at a clock edge) puts the block in idle with busy = 0, done = 0 and result = 0. It also abandons any computation in progress, which then never raises done.
- R2: start high at a clock edge while busy is 0 captures a..f at that edge, and busy reads 1 from the following cycle on.
- R3: result is the signed two's-complement value (a·b)·((c+d)+t6) − (a+e·f)·((c+d)·b), where t6 is the quarter of e·f. Operands are OPW-bit signed and result is 4·OPW+2 bits (34 bits by default).
- R4: If start is accepted at edge k, done is high for exactly one cycle, namely the cycle after edge k+5. The new result is valid in that same cycle.
- R5: While busy is 1, start pulses and changes on a..f have no effect on the result being computed, and they produce no extra done pulse.
- R6: result changes only in a cycle in which done is high, and holds its value otherwise.
- R7: The quarter of e·f rounds toward negative infinity. For example, e·f = −1 gives t6 = −1, and e·f = −5 gives t6 = −2.
- R8: Operands at the extremes of the signed range (all −128, all +127, and mixed) give the exact mathematical value without wrap-around.
- R9: busy stays high through the done cycle and falls in the next cycle. A start held high continuously is accepted again at the first edge after busy has fallen, so accepted starts are at least seven cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a computation (sampled only when idle) |
| op_a | input | OPW | Signed operand a |
| op_b | input | OPW | Signed operand b |
| op_c | input | OPW | Signed operand c |
| op_d | input | OPW | Signed operand d |
| op_e | input | OPW | Signed operand e |
| op_f | input | OPW | Signed operand f |
| busy | output | 1 | A computation is in progress, including its done cycle |
| done | output | 1 | One-cycle pulse: result has just been updated |
| result | output | 4·OPW+2 | Signed result, held between done pulses |

## Verification
Two events can land in the same cycle: a new start request and the done pulse of the computation still running. A second one is a start request and a reset. The bench holds start high across an entire computation and changes the operands part-way through. It then expects exactly two results: the first with the operands captured at the first edge, the second with the changed operands, accepted only at the edge after busy has fallen, with its done pulse at the predicted cycle. Any extra or early done pulse shows up as an unexpected scoreboard entry. A reset applied in the middle of a run must leave no done pulse behind.

// File: rtl/det_sched_pkg.sv
// Package: shared types for the time-shared determinant datapath.
// Assumes a single computation in flight; the step encoding is internal only.
package det_sched_pkg;

    // Controller steps: idle, five compute steps, one result-valid step.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_S1,
        ST_S2,
        ST_S3,
        ST_S4,
        ST_S5,
        ST_DONE
    } step_e;

    // Operand pair routed to the shared multiplier 0.
    typedef enum logic [1:0] {
        M0_AB,
        M0_T4B,
        M0_T1T7,
        M0_T3T5
    } m0_sel_e;

    // Operand pair routed to the single add/subtract unit.
    typedef enum logic [1:0] {
        AL_CD,
        AL_T4T6,
        AL_AT2,
        AL_T8T9
    } alu_sel_e;

    // Per-step control word from the controller to the datapath.
    typedef struct packed {
        m0_sel_e  m0_sel;
        alu_sel_e alu_sel;
        logic     alu_sub;
        logic     en_t1;
        logic     en_t2;
        logic     en_t3;
        logic     en_t4;
        logic     en_t5;
        logic     en_t7;
        logic     en_t8;
        logic     en_t9;
        logic     en_res;
    } ctrl_t;

    // Number of physical multipliers in the datapath.
    localparam int NMUL = 2;

endpackage

// File: rtl/det_sched_mul.sv
// Module: combinational signed multiplier, product truncated to W bits.
// Assumes the caller sizes W so that every product it forms fits.
module det_sched_mul #(
    parameter int W = 34
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] p
);

    // Signed product at the shared temporary width.
    always_comb p = a * b;

endmodule

// File: rtl/det_sched_alu.sv
// Module: combinational signed add/subtract unit.
// Assumes that results fit in W bits; no overflow flag is produced.
module det_sched_alu #(
    parameter int W = 34
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic                sub,
    output logic signed [W-1:0] y
);

    // Add or subtract according to the mode bit.
    always_comb y = sub ? (a - b) : (a + b);

endmodule

// File: rtl/det_sched_ctrl.sv
// Module: step sequencer. Walks IDLE -> S1..S5 -> DONE -> IDLE and
// issues the multiplexer selects and register enables for each step.
// Assumes start is synchronous to clk; start is ignored outside IDLE.
module det_sched_ctrl
    import det_sched_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    output logic  capture,
    output ctrl_t ctrl,
    output logic  busy,
    output logic  done
);

    step_e step_q;
    step_e step_d;

    // Next-step selection: fixed sequence once started.
    always_comb begin
        case (step_q)
            ST_IDLE: step_d = start ? ST_S1 : ST_IDLE;
            ST_S1:   step_d = ST_S2;
            ST_S2:   step_d = ST_S3;
            ST_S3:   step_d = ST_S4;
            ST_S4:   step_d = ST_S5;
            ST_S5:   step_d = ST_DONE;
            default: step_d = ST_IDLE;
        endcase
    end

    // Step register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_IDLE;
        else        step_q <= step_d;
    end

    // Status and operand capture strobe.
    always_comb begin
        capture = (step_q == ST_IDLE) && start;
        busy    = (step_q != ST_IDLE);
        done    = (step_q == ST_DONE);
    end

    // Control word: unit routing and register enables per step.
    always_comb begin
        ctrl         = '0;
        ctrl.m0_sel  = M0_AB;
        ctrl.alu_sel = AL_CD;
        case (step_q)
            ST_S1: begin
                ctrl.m0_sel  = M0_AB;
                ctrl.alu_sel = AL_CD;
                ctrl.en_t1   = 1'b1;
                ctrl.en_t2   = 1'b1;
                ctrl.en_t4   = 1'b1;
            end
            ST_S2: begin
                ctrl.m0_sel  = M0_T4B;
                ctrl.alu_sel = AL_T4T6;
                ctrl.en_t5   = 1'b1;
                ctrl.en_t7   = 1'b1;
            end
            ST_S3: begin
                ctrl.m0_sel  = M0_T1T7;
                ctrl.alu_sel = AL_AT2;
                ctrl.en_t8   = 1'b1;
                ctrl.en_t3   = 1'b1;
            end
            ST_S4: begin
                ctrl.m0_sel  = M0_T3T5;
                ctrl.en_t9   = 1'b1;
            end
            ST_S5: begin
                ctrl.alu_sel = AL_T8T9;
                ctrl.alu_sub = 1'b1;
                ctrl.en_res  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/det_sched_dp.sv
// Module: datapath with operand registers, temporaries, two multipliers
// and one add/subtract unit, all steered by the controller's control word.
// Assumes TW is large enough for every intermediate (4*OPW+2 suffices).
module det_sched_dp
    import det_sched_pkg::*;
#(
    parameter int OPW = 8,
    parameter int TW  = 4 * OPW + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  ctrl_t                 ctrl,
    input  logic signed [OPW-1:0] in_a,
    input  logic signed [OPW-1:0] in_b,
    input  logic signed [OPW-1:0] in_c,
    input  logic signed [OPW-1:0] in_d,
    input  logic signed [OPW-1:0] in_e,
    input  logic signed [OPW-1:0] in_f,
    output logic signed [TW-1:0]  res
);

    localparam int XW = TW - OPW;

    // Sign-extend an operand to the temporary width.
    function automatic logic signed [TW-1:0] sx(input logic signed [OPW-1:0] v);
        return {{XW{v[OPW-1]}}, v};
    endfunction

    logic signed [OPW-1:0] a_q, b_q, c_q, d_q, e_q, f_q;
    logic signed [TW-1:0]  t1_q, t2_q, t3_q, t4_q, t5_q, t7_q, t8_q, t9_q;
    logic signed [TW-1:0]  t6;
    logic signed [TW-1:0]  mul_a [NMUL];
    logic signed [TW-1:0]  mul_b [NMUL];
    logic signed [TW-1:0]  mul_p [NMUL];
    logic signed [TW-1:0]  alu_a, alu_b, alu_y;

    // Operand capture on an accepted start.
    always_ff @(posedge clk) begin
        if (capture) begin
            a_q <= in_a;
            b_q <= in_b;
            c_q <= in_c;
            d_q <= in_d;
            e_q <= in_e;
            f_q <= in_f;
        end
    end

    // Quarter of e*f: arithmetic shift, rounds toward negative infinity.
    always_comb t6 = t2_q >>> 2;

    // Multiplier 0 input routing per step.
    always_comb begin
        case (ctrl.m0_sel)
            M0_AB:   begin mul_a[0] = sx(a_q); mul_b[0] = sx(b_q); end
            M0_T4B:  begin mul_a[0] = t4_q;    mul_b[0] = sx(b_q); end
            M0_T1T7: begin mul_a[0] = t1_q;    mul_b[0] = t7_q;    end
            default: begin mul_a[0] = t3_q;    mul_b[0] = t5_q;    end
        endcase
    end

    // Multiplier 1 is dedicated to e*f.
    always_comb begin
        mul_a[1] = sx(e_q);
        mul_b[1] = sx(f_q);
    end

    // Add/subtract unit input routing per step.
    always_comb begin
        case (ctrl.alu_sel)
            AL_CD:   begin alu_a = sx(c_q); alu_b = sx(d_q); end
            AL_T4T6: begin alu_a = t4_q;    alu_b = t6;      end
            AL_AT2:  begin alu_a = sx(a_q); alu_b = t2_q;    end
            default: begin alu_a = t8_q;    alu_b = t9_q;    end
        endcase
    end

    // Multiplier bank.
    for (genvar m = 0; m < NMUL; m++) begin : g_mul
        det_sched_mul #(.W(TW)) u_mul (
            .a (mul_a[m]),
            .b (mul_b[m]),
            .p (mul_p[m])
        );
    end

    // Shared add/subtract unit.
    det_sched_alu #(.W(TW)) u_alu (
        .a   (alu_a),
        .b   (alu_b),
        .sub (ctrl.alu_sub),
        .y   (alu_y)
    );

    // Temporary registers written by the step that produces them.
    always_ff @(posedge clk) begin
        if (ctrl.en_t1) t1_q <= mul_p[0];
        if (ctrl.en_t2) t2_q <= mul_p[1];
        if (ctrl.en_t4) t4_q <= alu_y;
        if (ctrl.en_t5) t5_q <= mul_p[0];
        if (ctrl.en_t7) t7_q <= alu_y;
        if (ctrl.en_t8) t8_q <= mul_p[0];
        if (ctrl.en_t3) t3_q <= alu_y;
        if (ctrl.en_t9) t9_q <= mul_p[0];
    end

    // Result register: cleared by reset, written in the last step.
    always_ff @(posedge clk) begin
        if (!rst_n)           res <= '0;
        else if (ctrl.en_res) res <= alu_y;
    end

endmodule

// File: rtl/det_sched_top.sv
// Module: top of the time-shared determinant block. Connects the step
// sequencer to the datapath. One computation at a time; new result every
// seven cycles at best. Assumes synchronous inputs and active-low reset.
module det_sched_top
    import det_sched_pkg::*;
#(
    parameter int OPW  = 8,
    parameter int RESW = 4 * OPW + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic signed [OPW-1:0]  op_a,
    input  logic signed [OPW-1:0]  op_b,
    input  logic signed [OPW-1:0]  op_c,
    input  logic signed [OPW-1:0]  op_d,
    input  logic signed [OPW-1:0]  op_e,
    input  logic signed [OPW-1:0]  op_f,
    output logic                   busy,
    output logic                   done,
    output logic signed [RESW-1:0] result
);

    logic  capture;
    ctrl_t ctrl;

    // Step sequencer.
    det_sched_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .capture (capture),
        .ctrl    (ctrl),
        .busy    (busy),
        .done    (done)
    );

    // Arithmetic datapath.
    det_sched_dp #(.OPW(OPW), .TW(RESW)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .ctrl    (ctrl),
        .in_a    (op_a),
        .in_b    (op_b),
        .in_c    (op_c),
        .in_d    (op_d),
        .in_e    (op_e),
        .in_f    (op_f),
        .res     (result)
    );

endmodule

// File: rtl/det_sched_chk.sv
// Module: protocol checker for det_sched_top, attached by bind.
// Assumes reset is held low for at least two cycles.
module det_sched_chk #(
    parameter int RESW = 34
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [RESW-1:0] result
);

    // R2: an accepted start makes the block busy next cycle.
    p_busy_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4: done is a single-cycle pulse.
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done comes six edges after the accepting edge.
    p_done_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start && !busy, 6));

    // R5: a running computation cannot be cut short by start.
    p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6: result only moves in a done cycle.
    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R9: busy falls right after the done cycle.
    p_busy_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R1: idle implies no done pulse.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);

endmodule

bind det_sched_top det_sched_chk #(.RESW(RESW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/det_sched_top_tb_top.sv
// Bench: scoreboard. The driver pushes expected results with their due cycle,
// and the monitor pops and compares them when done is seen.
module det_sched_top_tb_top;

    localparam int OPW  = 8;
    localparam int RESW = 4 * OPW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [OPW-1:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0, op_e = '0, op_f = '0;
    logic busy, done;
    logic signed [RESW-1:0] result;

    typedef struct {
        longint val;
        longint due;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     n_chk = 0;
    int     n_fail = 0;
    longint cyc = 0;
    logic signed [RESW-1:0] prev_res = '0;

    det_sched_top #(.OPW(OPW)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_a   (op_a),
        .op_b   (op_b),
        .op_c   (op_c),
        .op_d   (op_d),
        .op_e   (op_e),
        .op_f   (op_f),
        .busy   (busy),
        .done   (done),
        .result (result)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Cycle counter.
    always @(posedge clk) cyc <= cyc + 1;

    // Independent model of the requirement formula (R3, R7).
    function automatic longint model(input int a, b, c, d, e, f);
        longint ef, q;
        ef = longint'(e) * longint'(f);
        q  = ef >>> 2;
        return (longint'(a) * b) * ((c + d) + q) - (a + ef) * ((longint'(c) + d) * b);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: wait for idle, issue one start, push the expected item.
    task automatic do_calc(input int a, b, c, d, e, f, input string tag);
        exp_t x;
        @(negedge clk);
        while (busy) @(negedge clk);
        op_a = OPW'(a); op_b = OPW'(b); op_c = OPW'(c);
        op_d = OPW'(d); op_e = OPW'(e); op_f = OPW'(f);
        start = 1'b1;
        x.val = model(a, b, c, d, e, f);
        x.due = cyc + 6;
        x.tag = tag;
        sb.push_back(x);
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after accept", longint'(busy), 1);
    endtask

    // Monitor: compare done results and check the hold behaviour.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_res = result;
        end else begin
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R5 unexpected done", longint'(result), 0);
                end else begin
                    exp_t x;
                    x = sb.pop_front();
                    check(longint'(result) == x.val, {x.tag, " value"}, longint'(result), x.val);
                    check(cyc == x.due, "R4 done cycle", cyc, x.due);
                end
            end else begin
                check(result == prev_res, "R6 result held", longint'(result), longint'(prev_res));
            end
            prev_res = result;
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (cycle %0d)", cyc);
        summary();
    end

    initial begin
        longint c0;
        int unsigned lf;
        exp_t x;

        repeat (4) @(negedge clk);
        // R1: reset state.
        check(busy === 1'b0, "R1 busy in reset", longint'(busy), 0);
        check(done === 1'b0, "R1 done in reset", longint'(done), 0);
        check(result === '0, "R1 result in reset", longint'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1 idle after reset", longint'(busy), 0);

        // R3: basic patterns.
        do_calc(0, 0, 0, 0, 0, 0, "R3 zeros");
        do_calc(1, 1, 1, 1, 1, 1, "R3 ones");
        do_calc(3, -5, 7, 2, 9, -4, "R3 mixed");
        do_calc(-12, 6, -3, 11, 5, 13, "R3 mixed2");
        // R7: flooring of the quarter.
        do_calc(2, 3, 4, 5, -1, 1, "R7 ef=-1");
        do_calc(-7, 2, 1, -6, 5, -1, "R7 ef=-5");
        do_calc(4, 4, 4, 4, 3, 3, "R7 ef=9");
        // R8: extremes.
        do_calc(-128, -128, -128, -128, -128, -128, "R8 all min");
        do_calc(127, 127, 127, 127, 127, 127, "R8 all max");
        do_calc(-128, 127, -128, -128, -128, 127, "R8 mixed ext");
        do_calc(127, -128, 127, 127, -128, -128, "R8 mixed ext2");

        // R3: pseudo-random vectors from an LFSR.
        lf = 32'hACE1_1234;
        for (int i = 0; i < 12; i++) begin
            int v[6];
            for (int k = 0; k < 6; k++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                v[k] = int'($signed(lf[7:0]));
            end
            do_calc(v[0], v[1], v[2], v[3], v[4], v[5], "R3 random");
        end

        // R5: start pulses and operand changes during a run are ignored.
        do_calc(9, -3, 5, 6, -7, 2, "R5 protected run");
        op_a = 8'sd100; op_e = -8'sd77;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op_b = 8'sd55;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R5 no extra result", sb.size(), 0);

        // R9: start held high across a whole run.
        @(negedge clk);
        c0 = cyc;
        op_a = 8'sd5; op_b = 8'sd6; op_c = -8'sd7; op_d = 8'sd8; op_e = 8'sd9; op_f = -8'sd10;
        start = 1'b1;
        x.val = model(5, 6, -7, 8, 9, -10); x.due = c0 + 6; x.tag = "R9 held first";
        sb.push_back(x);
        x.val = model(-20, 3, 14, -2, -11, 6); x.due = c0 + 13; x.tag = "R9 held second";
        sb.push_back(x);
        @(negedge clk);
        op_a = -8'sd20; op_b = 8'sd3; op_c = 8'sd14; op_d = -8'sd2; op_e = -8'sd11; op_f = 8'sd6;
        while (cyc < c0 + 7) @(negedge clk);
        check(busy === 1'b0, "R9 busy fell after done", longint'(busy), 0);
        @(negedge clk);
        check(busy === 1'b1, "R9 held start re-accepted", longint'(busy), 1);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(sb.size() == 0, "R9 both results seen", sb.size(), 0);

        // R1: reset in the middle of a run abandons it.
        @(negedge clk);
        op_a = 8'sd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(busy === 1'b0, "R1 busy after mid-run reset", longint'(busy), 0);
        check(result === '0, "R1 result after mid-run reset", longint'(result), 0);
        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R1 no stray done", sb.size(), 0);

        // Final sanity run after reset.
        do_calc(-1, -1, -1, -1, -1, -1, "R3 after reset");
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
        summary();
    end

endmodule